// File: doc/BRIEF.md
# PWM / Hysteretic Operating-Mode Selector

This block chooses between fixed-frequency PWM and light-load hysteretic operation for a synchronous buck converter. Once per switching cycle, in the window where the low-side switch conducts and just before the high side turns on, a comparator reports the polarity of the switch node. The block receives that result together with a strobe that marks the sample as valid. A negative node means forward inductor current; a positive node means current flowing back from the load.

A change of mode needs a run of eight consecutive samples of the sign that opposes the present mode. Any sample of the wrong sign starts the run again, so the mode does not chatter near the boundary load. There are three faster ways back to PWM. The first is an output dip below the hysteretic regulation level. The second is an external force-PWM input. The third is a flag that is raised during soft start and setpoint transitions.

While in hysteretic mode, the block asks for high-side conduction from the moment the output falls below a lower threshold until it rises above an upper threshold. Each threshold comes from its own comparator.

Top module: `pwm_hyst_mode_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `hyst_mode` is 0 (PWM) and `hs_req` is 0.
- R2: In PWM mode (`hyst_mode`=0), `hyst_mode` becomes 1 on the clock edge that registers the 8th consecutive strobed sample with `sw_pos`=1. After 7 such samples the block is still in PWM.
- R3: In hysteretic mode (`hyst_mode`=1), `hyst_mode` becomes 0 on the clock edge that registers the 8th consecutive strobed sample with `sw_pos`=0.
- R4: A strobed sample whose sign does not match the sign being counted clears the run. After a mode change, the run also starts from zero.
- R5: In hysteretic mode, `out_dip`=1 returns the block to PWM on the next clock edge. In PWM mode, `out_dip` has no effect, and the run of samples is not cleared.
- R6: `fpwm_n`=0 holds PWM from the next edge onward and clears the run. An exit from hysteretic mode caused this way takes effect on the next edge.
- R7: `xfer_busy`=1 (soft start or setpoint transition) has the same effect as `fpwm_n`=0.
- R8: In hysteretic mode, `hs_req` goes to 1 on the edge after `below_lo`=1. It goes to 0 on the edge after `above_hi`=1, and `above_hi` wins if both are high. With neither high, `hs_req` holds its value.
- R9: `hs_req` is 0 in every cycle where `hyst_mode` is 0, including the cycle in which the mode falls back to PWM.
- R10: `sw_pos` is ignored when `sample_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle strobe marking a valid switch-node polarity sample |
| sw_pos | input | 1 | Switch-node polarity: 1 = positive (reverse current), 0 = negative |
| out_dip | input | 1 | Output below the hysteretic regulation level |
| fpwm_n | input | 1 | 0 forces PWM operation |
| xfer_busy | input | 1 | Soft start or setpoint transition in progress |
| below_lo | input | 1 | Output below the lower hysteretic threshold |
| above_hi | input | 1 | Output above the upper hysteretic threshold |
| hyst_mode | output | 1 | 1 = hysteretic mode, 0 = PWM |
| hs_req | output | 1 | High-side conduction request in hysteretic mode |

## Verification
The run filter is exercised with several sample patterns. Unbroken runs of seven and eight samples pin down the exact switching threshold. A run broken late tells a clearing counter apart from one that merely pauses. Strobe-free toggling of the polarity input separates sampling on the strobe from sampling on every clock. Each of the three fast exits to PWM is applied in both modes, partway through a run. This shows that an exit acts on the next edge, and that a force or transition flag wipes a partial run while an output dip in PWM does not. The pulse request is driven through set, hold, clear and both-high cases, and is also left high across a mode exit.

// File: rtl/pwm_hyst_pkg.sv
package pwm_hyst_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } conv_mode_e;

  // Polarity that argues for leaving the given mode.
  function automatic logic exit_sign(input conv_mode_e m);
    return (m == MODE_PWM);
  endfunction
endpackage

// File: rtl/pol_run_counter.sv
module pol_run_counter #(
  parameter int RUN_LEN = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample_stb,
  input  logic             sw_pos,
  input  logic             want_pos,
  output logic             run_done,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic match;
  assign match    = (sw_pos == want_pos);
  assign run_done = sample_stb && match && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (sample_stb) begin
      if (!match || run_done) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import pwm_hyst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inhibit,
  input  logic       out_dip,
  input  logic       run_done,
  output conv_mode_e mode_q,
  output conv_mode_e mode_d
);
  always_comb begin
    mode_d = mode_q;
    if (inhibit)                              mode_d = MODE_PWM;
    else if (mode_q == MODE_HYST && out_dip)  mode_d = MODE_PWM;
    else if (run_done)
      mode_d = (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_PWM;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/hyst_pulse_gen.sv
module hyst_pulse_gen
  import pwm_hyst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  conv_mode_e mode_d,
  input  logic       below_lo,
  input  logic       above_hi,
  output logic       req_q
);
  always_ff @(posedge clk) begin
    if (rst || mode_d != MODE_HYST) req_q <= 1'b0;
    else if (above_hi)               req_q <= 1'b0;
    else if (below_lo)               req_q <= 1'b1;
  end
endmodule

// File: rtl/pwm_hyst_mode_sel.sv
module pwm_hyst_mode_sel
  import pwm_hyst_pkg::*;
#(
  parameter int RUN_LEN = 8,
  parameter int CNT_W   = $clog2(RUN_LEN) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_stb,
  input  logic sw_pos,
  input  logic out_dip,
  input  logic fpwm_n,
  input  logic xfer_busy,
  input  logic below_lo,
  input  logic above_hi,
  output logic hyst_mode,
  output logic hs_req
);
  conv_mode_e       mode_q, mode_d;
  logic             inhibit, run_done, run_clear;
  logic [CNT_W-1:0] run_cnt;

  assign inhibit   = !fpwm_n || xfer_busy;
  assign run_clear = inhibit || (mode_d != mode_q);

  pol_run_counter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .clear(run_clear), .sample_stb(sample_stb),
    .sw_pos(sw_pos), .want_pos(exit_sign(mode_q)),
    .run_done(run_done), .cnt_q(run_cnt)
  );

  mode_ctrl u_mode (
    .clk(clk), .rst(rst), .inhibit(inhibit), .out_dip(out_dip),
    .run_done(run_done), .mode_q(mode_q), .mode_d(mode_d)
  );

  hyst_pulse_gen u_pulse (
    .clk(clk), .rst(rst), .mode_d(mode_d), .below_lo(below_lo),
    .above_hi(above_hi), .req_q(hs_req)
  );

  assign hyst_mode = (mode_q == MODE_HYST);
endmodule

// File: rtl/pwm_hyst_mode_sel_chk.sv
module pwm_hyst_mode_sel_chk #(
  parameter int RUN_LEN = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_stb,
  input logic             sw_pos,
  input logic             out_dip,
  input logic             fpwm_n,
  input logic             xfer_busy,
  input logic             above_hi,
  input logic             hyst_mode,
  input logic             hs_req,
  input logic [CNT_W-1:0] run_cnt
);
  AST_RESET_PWM: assert property (@(posedge clk) rst |=> !hyst_mode && !hs_req); // R1
  AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(hyst_mode) |-> $past(sample_stb && sw_pos)); // R2
  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(hyst_mode) |-> $past(out_dip || !fpwm_n || xfer_busy || (sample_stb && !sw_pos))); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt < CNT_W'(RUN_LEN)); // R4
  AST_DIP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (hyst_mode && out_dip) |=> !hyst_mode); // R5
  AST_FORCE_PWM: assert property (@(posedge clk) disable iff (rst)
    !fpwm_n |=> !hyst_mode && run_cnt == '0); // R6
  AST_XFER_PWM: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |=> !hyst_mode && run_cnt == '0); // R7
  AST_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    above_hi |=> !hs_req); // R8
  AST_REQ_ONLY_HYST: assert property (@(posedge clk) disable iff (rst)
    hs_req |-> hyst_mode); // R9
  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && fpwm_n && !xfer_busy && !out_dip) |=> $stable(hyst_mode)); // R10
endmodule

bind pwm_hyst_mode_sel pwm_hyst_mode_sel_chk #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sample_stb(sample_stb), .sw_pos(sw_pos),
  .out_dip(out_dip), .fpwm_n(fpwm_n), .xfer_busy(xfer_busy),
  .above_hi(above_hi), .hyst_mode(hyst_mode), .hs_req(hs_req),
  .run_cnt(run_cnt)
);

// File: tb/test_pwm_hyst_mode_sel.sv
module test_pwm_hyst_mode_sel;
  logic clk = 1'b0;
  logic rst, sample_stb, sw_pos, out_dip, fpwm_n, xfer_busy, below_lo, above_hi;
  logic hyst_mode, hs_req;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pwm_hyst_mode_sel i_pwm_hyst_mode_sel (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .sw_pos(sw_pos),
    .out_dip(out_dip), .fpwm_n(fpwm_n), .xfer_busy(xfer_busy),
    .below_lo(below_lo), .above_hi(above_hi),
    .hyst_mode(hyst_mode), .hs_req(hs_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Inputs change at negedge; one posedge later results are read at the next negedge.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic pos, input int n);
    for (int i = 0; i < n; i++) begin
      sample_stb = 1'b1; sw_pos = pos;
      @(negedge clk);
      sample_stb = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sample_stb = 0; sw_pos = 0; out_dip = 0; fpwm_n = 1;
    xfer_busy = 0; below_lo = 0; above_hi = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(1);
    chk("R1 mode in reset", hyst_mode, 1'b0);
    chk("R1 req in reset", hs_req, 1'b0);
    rst = 1'b0; idle(1);
    chk("R1 mode after reset", hyst_mode, 1'b0);
  endtask

  task automatic t_entry();
    do_reset();
    strobe(1, 7);
    chk("R2 seven positives stay PWM", hyst_mode, 1'b0);
    strobe(1, 1);
    chk("R2 eighth positive enters hyst", hyst_mode, 1'b1);
    strobe(0, 7);
    chk("R4 run restarts after change", hyst_mode, 1'b1);
    strobe(0, 1);
    chk("R3 eighth negative returns PWM", hyst_mode, 1'b0);
  endtask

  task automatic t_mismatch();
    do_reset();
    strobe(1, 7); strobe(0, 1); strobe(1, 7);
    chk("R4 mismatch clears PWM run", hyst_mode, 1'b0);
    strobe(1, 1);
    chk("R4 full run after mismatch", hyst_mode, 1'b1);
    strobe(0, 7); strobe(1, 1); strobe(0, 7);
    chk("R4 mismatch clears hyst run", hyst_mode, 1'b1);
    strobe(0, 1);
    chk("R3 exit after clean run", hyst_mode, 1'b0);
  endtask

  task automatic t_no_strobe();
    do_reset();
    strobe(1, 4);
    for (int i = 0; i < 10; i++) begin
      sw_pos = i[0]; @(negedge clk);
    end
    strobe(1, 3);
    chk("R10 unstrobed samples ignored", hyst_mode, 1'b0);
    strobe(1, 1);
    chk("R10 run kept across unstrobed cycles", hyst_mode, 1'b1);
  endtask

  task automatic t_dip();
    do_reset();
    strobe(1, 4);
    out_dip = 1; @(negedge clk); out_dip = 0;
    chk("R5 dip ignored in PWM", hyst_mode, 1'b0);
    strobe(1, 4);
    chk("R5 dip in PWM keeps run", hyst_mode, 1'b1);
    out_dip = 1; @(negedge clk); out_dip = 0;
    chk("R5 dip exits hyst next edge", hyst_mode, 1'b0);
  endtask

  task automatic t_inhibit(input bit use_busy, input string tag);
    do_reset();
    strobe(1, 4);
    if (use_busy) xfer_busy = 1; else fpwm_n = 0;
    strobe(1, 10);
    chk({tag, " no entry while held"}, hyst_mode, 1'b0);
    xfer_busy = 0; fpwm_n = 1;
    strobe(1, 4);
    chk({tag, " run cleared by hold"}, hyst_mode, 1'b0);
    strobe(1, 4);
    chk({tag, " entry after release"}, hyst_mode, 1'b1);
    if (use_busy) xfer_busy = 1; else fpwm_n = 0;
    @(negedge clk);
    chk({tag, " exit next edge"}, hyst_mode, 1'b0);
    xfer_busy = 0; fpwm_n = 1;
  endtask

  task automatic t_pulse();
    do_reset();
    below_lo = 1; @(negedge clk);
    chk("R9 no request in PWM", hs_req, 1'b0);
    below_lo = 0;
    strobe(1, 8);
    chk("R8 in hyst before request", hs_req, 1'b0);
    below_lo = 1; @(negedge clk); below_lo = 0;
    chk("R8 request set", hs_req, 1'b1);
    idle(3);
    chk("R8 request held", hs_req, 1'b1);
    above_hi = 1; @(negedge clk); above_hi = 0;
    chk("R8 request cleared", hs_req, 1'b0);
    below_lo = 1; above_hi = 1; @(negedge clk); above_hi = 0;
    chk("R8 upper threshold wins", hs_req, 1'b0);
    @(negedge clk); below_lo = 0;
    chk("R8 set again", hs_req, 1'b1);
    out_dip = 1; @(negedge clk); out_dip = 0;
    chk("R9 mode exit", hyst_mode, 1'b0);
    chk("R9 request drops with mode", hs_req, 1'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_entry();
    t_mismatch();
    t_no_strobe();
    t_dip();
    t_inhibit(1'b0, "R6");
    t_inhibit(1'b1, "R7");
    t_pulse();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule